// File: doc/BRIEF.md
# Low Power Idle Entry Controller

This block decides, for one port, when the transmitter should be asked to enter Low Power Idle and when it must return to normal operation. A prescaler divides the core clock into a microsecond tick (25 clocks at 25 MHz by default). While every unmasked entry condition holds and both enables are high, an idle counter advances on that tick. When it reaches a programmable 32-bit threshold, the block raises its LPI request.

While in LPI, the block watches a separate set of exit events. Some are level indications. Others are the falling edges of the receive-LPI status and the link L1 status, which only the exit side can see. Any unmasked exit event, or either enable going low, returns the block to the active state on the next clock. Each entry into LPI increments a wrapping statistic counter.

Sixteen event lines come in as levels. Two further event positions (16 and 17) are derived inside the block from falling edges. Each of the two masks therefore covers 18 event positions.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, lpi_req_o is 0 and ent_cnt_o is 0, and the idle counter and prescaler start from zero.
- R2: The idle count advances once every TICK_DIV clocks. If the entry conditions hold from some cycle on, lpi_req_o rises after exactly TICK_DIV*idle_thr_i rising edges.
- R3: Entry is qualified only when every entry-applicable event bit is 1 or has its ent_mask_i bit set to 1. A mask bit of 1 disables an event and 0 enables it. Event positions: 0 power sequencer done, 1 all queues empty, 3 fetch request, 4 other transmit request, 5 receive LPI status, 6 transmit pause, 7 receive buffer empty, 8 queue idle, 9 loopback queue idle, 10 L1 status, 11-14 per-port LPI requests, 15 L1 request.
- R4: Entry-mask positions 2, 16 and 17 have no effect on entry.
- R5: In any cycle where entry is not qualified, an unmasked exit event is present or an enable is low, the idle count and prescaler restart, so a full threshold period is needed again.
- R6: A threshold of 0 never enters LPI.
- R7: LPI is requested only while both fw_en_i and drv_en_i are 1. If either drops while in LPI, lpi_req_o falls on the next edge.
- R8: For exit positions 0-4, 6-9 and 11-15, a high evt_i bit with its ext_mask_i bit at 0 ends LPI on the next edge. With the mask bit at 1 it is ignored.
- R9: Exit positions 5 and 16 act on a 1-to-0 change of evt_i[5] between consecutive clocks, and positions 10 and 17 on a 1-to-0 change of evt_i[10]. Levels and rising changes on these lines never end LPI.
- R10: Once in LPI, loss of entry conditions alone does not end LPI.
- R11: ent_cnt_o increments by one at the same edge where lpi_req_o rises, holds otherwise, and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| evt_i | input | 16 | Level event indications, positions 0-15 |
| fw_en_i | input | 1 | Firmware LPI enable |
| drv_en_i | input | 1 | Driver LPI enable |
| ent_mask_i | input | 18 | Entry event mask, 1 disables |
| ext_mask_i | input | 18 | Exit event mask, 1 disables |
| idle_thr_i | input | THR_W (32) | Idle threshold in ticks |
| lpi_req_o | output | 1 | LPI request |
| ent_cnt_o | output | CNT_W (16) | LPI entry statistic counter |

## Verification
The bench measures the entry latency for several thresholds and sweeps every entry and exit position. This exposes an off-by-one tick, where entry would land a multiple of the divider early or late, and a swapped or mis-positioned event bit, where the wrong line would block entry or end LPI. Edge-only exits are driven high, held and released with the mask both set and clear. A design that reacts to levels or rising changes would drop LPI too early, and one that ignores the mask would drop it when masked. A one-cycle break in the entry conditions just before the threshold shows whether the count truly restarts. A run of more entries than the counter range checks the wrap back to zero.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  localparam int unsigned EVT_N    = 18;
  localparam int unsigned EVT_IN_N = 16;

  localparam int unsigned EV_EARLY_EXIT = 2;
  localparam int unsigned EV_RX_LPI     = 5;
  localparam int unsigned EV_L1_STAT    = 10;
  localparam int unsigned EV_RX_FALL    = 16;
  localparam int unsigned EV_L1_FALL    = 17;

  localparam logic [EVT_N-1:0] ONE_HOT0 = EVT_N'(1);
  localparam logic [EVT_N-1:0] ENTRY_USE =
    ~((ONE_HOT0 << EV_EARLY_EXIT) | (ONE_HOT0 << EV_RX_FALL) | (ONE_HOT0 << EV_L1_FALL));
  localparam logic [EVT_N-1:0] RX_EDGE_SEL = (ONE_HOT0 << EV_RX_LPI) | (ONE_HOT0 << EV_RX_FALL);
  localparam logic [EVT_N-1:0] L1_EDGE_SEL = (ONE_HOT0 << EV_L1_STAT) | (ONE_HOT0 << EV_L1_FALL);

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_LPI    = 1'b1
  } lpi_state_e;
endpackage

// File: rtl/eee_lpi_tick.sv
module eee_lpi_tick #(
  parameter int unsigned DIV = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (!run_i)          pre_q <= '0;
    else if (pre_q == LAST)   pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == LAST);

  // ticks are never back to back
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/eee_lpi_evt_qual.sv
module eee_lpi_evt_qual
  import eee_lpi_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [EVT_IN_N-1:0] evt_i,
  input  logic [EVT_N-1:0]    ent_mask_i,
  input  logic [EVT_N-1:0]    ext_mask_i,
  output logic                entry_ok_o,
  output logic                exit_hit_o
);
  logic prev_rx_q, prev_l1_q;
  logic fall_rx, fall_l1;
  logic [EVT_N-1:0] evt_full, ent_term, exit_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_rx_q <= 1'b0;
      prev_l1_q <= 1'b0;
    end else begin
      prev_rx_q <= evt_i[EV_RX_LPI];
      prev_l1_q <= evt_i[EV_L1_STAT];
    end
  end

  assign fall_rx  = prev_rx_q & ~evt_i[EV_RX_LPI];
  assign fall_l1  = prev_l1_q & ~evt_i[EV_L1_STAT];
  assign evt_full = {fall_l1, fall_rx, evt_i};

  // positions not used for entry count as satisfied
  assign ent_term   = evt_full | ent_mask_i | ~ENTRY_USE;
  assign entry_ok_o = &ent_term;

  for (genvar g = 0; g < EVT_N; g++) begin : g_exit_src
    if (RX_EDGE_SEL[g]) begin : g_rx
      assign exit_src[g] = fall_rx;
    end else if (L1_EDGE_SEL[g]) begin : g_l1
      assign exit_src[g] = fall_l1;
    end else begin : g_lvl
      assign exit_src[g] = evt_full[g];
    end
  end

  assign exit_hit_o = |(exit_src & ~ext_mask_i);

  // a status line held high never produces an exit through the edge positions
  p_edge_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[EV_RX_LPI] && evt_i[EV_L1_STAT] && ((ext_mask_i | RX_EDGE_SEL | L1_EDGE_SEL) == '1))
      |-> !exit_hit_o);
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_lpi_pkg::*;
#(
  parameter int unsigned THR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             entry_ok_i,
  input  logic             exit_hit_i,
  input  logic             gate_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             run_o,
  output logic             enter_o,
  output logic             lpi_o
);
  lpi_state_e       state_q;
  logic [THR_W-1:0] idle_q;
  logic             reach;

  assign run_o   = (state_q == ST_ACTIVE) && gate_i && entry_ok_i && !exit_hit_i && (thr_i != '0);
  assign reach   = ({1'b0, idle_q} + (THR_W+1)'(1)) >= {1'b0, thr_i};
  assign enter_o = run_o && tick_i && reach;
  assign lpi_o   = (state_q == ST_LPI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      idle_q  <= '0;
    end else begin
      unique case (state_q)
        ST_ACTIVE: begin
          if (enter_o) begin
            state_q <= ST_LPI;
            idle_q  <= '0;
          end else if (!run_o) begin
            idle_q  <= '0;
          end else if (tick_i) begin
            idle_q  <= idle_q + 1'b1;
          end
        end
        ST_LPI: begin
          idle_q <= '0;
          if (exit_hit_i || !gate_i) state_q <= ST_ACTIVE;
        end
        default: state_q <= ST_ACTIVE;
      endcase
    end
  end

  p_exit_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpi_o && exit_hit_i) |=> !lpi_o);

  p_thr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lpi_o && thr_i == '0) |=> !lpi_o);

  p_lpi_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpi_o && gate_i && !exit_hit_i) |=> lpi_o);

  p_no_tick_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_ok_i |-> !enter_o);
endmodule

// File: rtl/eee_lpi_stat.sv
module eee_lpi_stat #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (enter_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int unsigned TICK_DIV = 25,
  parameter int unsigned THR_W    = 32,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [EVT_IN_N-1:0] evt_i,
  input  logic                fw_en_i,
  input  logic                drv_en_i,
  input  logic [EVT_N-1:0]    ent_mask_i,
  input  logic [EVT_N-1:0]    ext_mask_i,
  input  logic [THR_W-1:0]    idle_thr_i,
  output logic                lpi_req_o,
  output logic [CNT_W-1:0]    ent_cnt_o
);
  logic gate, entry_ok, exit_hit, run, tick, enter;

  assign gate = fw_en_i & drv_en_i;

  eee_lpi_evt_qual i_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .ent_mask_i (ent_mask_i),
    .ext_mask_i (ext_mask_i),
    .entry_ok_o (entry_ok),
    .exit_hit_o (exit_hit)
  );

  eee_lpi_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  eee_lpi_fsm #(.THR_W(THR_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .entry_ok_i (entry_ok),
    .exit_hit_i (exit_hit),
    .gate_i     (gate),
    .thr_i      (idle_thr_i),
    .run_o      (run),
    .enter_o    (enter),
    .lpi_o      (lpi_req_o)
  );

  eee_lpi_stat #(.CNT_W(CNT_W)) i_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter),
    .cnt_o   (ent_cnt_o)
  );

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fw_en_i && drv_en_i) |=> !lpi_req_o);

  p_cnt_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lpi_req_o) |-> ent_cnt_o == CNT_W'($past(ent_cnt_o) + 1'b1));

  p_cnt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(lpi_req_o) |-> $stable(ent_cnt_o));
endmodule

// File: tb/test_eee_lpi_ctrl.sv
module test_eee_lpi_ctrl;
  localparam int DIV = 5;
  localparam int CW  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        fw = 1'b0, drv = 1'b0;
  logic [17:0] ent_mask = '1, ext_mask = '1;
  logic [31:0] thr = '0;
  logic        lpi;
  logic [CW-1:0] cnt;

  int checks = 0, fails = 0, exp_cnt = 0;

  always #10 clk = ~clk;

  eee_lpi_ctrl #(.TICK_DIV(DIV), .THR_W(32), .CNT_W(CW)) i_eee_lpi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .fw_en_i(fw), .drv_en_i(drv),
    .ent_mask_i(ent_mask), .ext_mask_i(ext_mask), .idle_thr_i(thr),
    .lpi_req_o(lpi), .ent_cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic park();
    drv = 0; fw = 0; evt = '0; ent_mask = '1; ext_mask = '1;
    step(2);
  endtask

  task automatic measure(input int lim, output int n);
    bit done = 0;
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      if (!done) begin
        @(negedge clk);
        if (lpi) begin n = k; done = 1; end
      end
    end
  endtask

  task automatic enter_chk(input int t, input string req);
    int n;
    thr = 32'(t); fw = 1; drv = 1;
    measure(DIV * t + 10, n);
    chk(n == DIV * t, req, n, DIV * t);
    if (n != 0) exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk(int'(cnt) == exp_cnt, "R11 count", int'(cnt), exp_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    step(3);
    rst_n = 1;
    step(1);
    // R1
    chk(lpi == 0, "R1 lpi", int'(lpi), 0);
    chk(cnt == 0, "R1 cnt", int'(cnt), 0);

    // R2 latency across thresholds
    for (int t = 1; t <= 4; t++) begin
      park();
      enter_chk(t, "R2 latency");
    end

    // R6 zero threshold
    park();
    thr = 0; fw = 1; drv = 1;
    step(60);
    chk(lpi == 0, "R6 zero thr", int'(lpi), 0);

    // R7 enables
    park();
    thr = 1; fw = 1; drv = 0; step(4 * DIV);
    chk(lpi == 0, "R7 drv low", int'(lpi), 0);
    fw = 0; drv = 1; step(4 * DIV);
    chk(lpi == 0, "R7 fw low", int'(lpi), 0);
    park();
    enter_chk(1, "R7 entry");
    fw = 0; step(1);
    chk(lpi == 0, "R7 fw drop exit", int'(lpi), 0);
    park();
    enter_chk(1, "R7 entry");
    drv = 0; step(1);
    chk(lpi == 0, "R7 drv drop exit", int'(lpi), 0);

    // R3 entry position sweep
    for (int i = 0; i < 16; i++) begin
      if (i != 2) begin
        park();
        ent_mask = ~(18'(1) << i);
        thr = 1; fw = 1; drv = 1;
        step(3 * DIV);
        chk(lpi == 0, $sformatf("R3 blocked bit%0d", i), int'(lpi), 0);
        evt[i] = 1'b1;
        measure(DIV + 10, n);
        chk(n == DIV, $sformatf("R3 enter bit%0d", i), n, DIV);
        if (n != 0) exp_cnt = (exp_cnt + 1) % (1 << CW);
      end
    end

    // R4 non-entry positions unmasked with events low
    park();
    ent_mask = 18'h3FFFF & ~18'h30004;
    enter_chk(1, "R4 ignored positions");

    // R5 restart on a one-cycle break
    park();
    ent_mask = ~18'h1; evt[0] = 1; thr = 2; fw = 1; drv = 1;
    step(2 * DIV - 1);
    chk(lpi == 0, "R5 before threshold", int'(lpi), 0);
    evt[0] = 0; step(1);
    evt[0] = 1;
    measure(2 * DIV + 10, n);
    chk(n == 2 * DIV, "R5 restart", n, 2 * DIV);
    if (n != 0) exp_cnt = (exp_cnt + 1) % (1 << CW);

    // R8 level exit sweep
    for (int i = 0; i < 16; i++) begin
      if (i != 5 && i != 10) begin
        park();
        enter_chk(1, "R8 entry");
        evt[i] = 1; step(2);
        chk(lpi == 1, $sformatf("R8 masked bit%0d", i), int'(lpi), 1);
        ext_mask = ~(18'(1) << i); step(1);
        chk(lpi == 0, $sformatf("R8 exit bit%0d", i), int'(lpi), 0);
      end
    end

    // R9 edge exits
    for (int j = 0; j < 4; j++) begin
      int m, s;
      m = (j == 0) ? 5 : (j == 1) ? 16 : (j == 2) ? 10 : 17;
      s = (j < 2) ? 5 : 10;
      park();
      enter_chk(1, "R9 entry");
      evt[s] = 1; step(2);
      evt[s] = 0; step(2);
      chk(lpi == 1, $sformatf("R9 masked fall pos%0d", m), int'(lpi), 1);
      ext_mask = ~(18'(1) << m);
      evt[s] = 1; step(2);
      chk(lpi == 1, $sformatf("R9 rise/level pos%0d", m), int'(lpi), 1);
      evt[s] = 0; step(1);
      chk(lpi == 0, $sformatf("R9 fall exit pos%0d", m), int'(lpi), 0);
    end

    // R10 entry loss in LPI
    park();
    ent_mask = ~18'h1; evt[0] = 1;
    enter_chk(1, "R10 entry");
    evt[0] = 0; step(3);
    chk(lpi == 1, "R10 sticky", int'(lpi), 1);

    // R11 wrap
    park();
    for (int k = 0; k < 18; k++) begin
      enter_chk(1, "R11 wrap entry");
      drv = 0; step(2);
    end
    chk(int'(cnt) == exp_cnt, "R11 after wrap", int'(cnt), exp_cnt);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule